// File: doc/BRIEF.md
# Page-Mode DRAM Access Sequencer

The sequencer takes one CPU memory request at a time. A request is a read or a write, and it is either a single 64-bit transfer or a four-transfer burst. At the moment of acceptance it compares the request's row with the row it holds open and sorts the request into one of four classes: page hit, row miss, page miss, or closed-row mode. Each class has its own first-transfer latency. Later burst transfers follow at a fixed cadence.

From one down-counter it drives the following signals:
- an active-low row strobe;
- eight active-low column strobes;
- a multiplexed row/column address;
- a ready strobe back to the CPU, one per transfer;
- a two-bit data-path control code;
- an active-high read-data latch enable.

The column address steps through the CPU's interleaved burst order. A mode input chooses between two row policies. In the first, the row is left open after an access so that later hits are fast. In the second, the row strobe is closed after every access.

All clock counts are parameters. The default latencies are:

| Access class | Read first transfer | Write first transfer |
|---|---|---|
| Page hit | 7 | 12 |
| Row miss | 11 | 13 |
| Page miss | 14 | 16 |
| Closed-row mode | 10 | 12 |

Each later transfer of a burst takes 4 clocks.

Top module: `pmdram_seq`

## Requirements
- R1: During and right after reset, the outputs are idle: `ras_n` high, all `cas_n` high, `cpu_rdy` low, `dp_code` 0, `mdle` high, `req_ready` high.
- R2: A read accepted in open-row mode is classified against the open row and produces its first `cpu_rdy` after 7 clocks (page hit), 11 clocks (no row open, row miss) or 14 clocks (another row open, page miss). The latency is counted from the accepting clock edge. The row is `req_addr[21:11]` and the column is `req_addr[10:0]`.
- R3: A write in open-row mode produces its first `cpu_rdy` after 12 clocks (page hit), 13 clocks (row miss) or 16 clocks (page miss).
- R4: With `close_mode` high, the first transfer takes 10 clocks for a read and 12 clocks for a write. `ras_n` is high once the access ends, and no row counts as open afterwards.
- R5: Each later burst transfer raises `cpu_rdy` 4 clocks after the previous one. A single access gives exactly one `cpu_rdy`. `cpu_rdy` never stays high for two clocks in a row.
- R6: In the cycle of the ready strobe for transfer n (n = 0..3), `ma` holds the column with its two low bits replaced by (start low bits XOR n). The upper column bits are unchanged.
- R7: All eight `cas_n` are low in every `cpu_rdy` cycle. All are high in the cycle after it.
- R8: `mdle` falls for exactly the one cycle after each read transfer's `cpu_rdy`, when `cas_n` is high. It stays high for writes.
- R9: `dp_code` is 1 during a read and 2 during a write. It is 0 (no operation) in the final `cpu_rdy` cycle and while idle.
- R10: For a page miss, and for a closed-mode access while a row is open, `ras_n` is high in the first cycle after acceptance. `ras_n` is low in every `cpu_rdy` cycle, and stays low while idle after an open-mode access.
- R11: `req_ready` is high only while idle. A request is taken only on a clock edge where `req_valid` and `req_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| close_mode | input | 1 | 1: close the row after each access |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1: write, 0: read |
| req_burst | input | 1 | 1: four transfers, 0: one transfer |
| req_addr | input | 22 | Qword address {row, column} |
| req_ready | output | 1 | Sequencer idle, request accepted |
| cpu_rdy | output | 1 | Transfer-complete strobe |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 8 | Column strobes, active low |
| ma | output | 11 | Multiplexed row/column address |
| dp_code | output | 2 | Data-path control code |
| mdle | output | 1 | Read-data latch enable |

## Verification
Two things can fall in the same clock. The first is the latch-closing `mdle` pulse for the final read transfer. The second is the acceptance of the next request, which is already waiting on `req_valid`.

The bench provokes this with a read single whose successor is presented before the read finishes. The successor is a write to a different row. The bench then checks three things in that clock: `mdle` is low, `req_ready` is high, and `ras_n` goes high on the next clock. It also checks that the successor's first transfer lands at exactly the page-miss write latency, counted from that shared clock.

// File: rtl/pmdram_pkg.sv
package pmdram_pkg;
   typedef enum logic [1:0] {
      ACC_HIT      = 2'd0,
      ACC_ROWMISS  = 2'd1,
      ACC_PAGEMISS = 2'd2,
      ACC_CLOSED   = 2'd3
   } acc_cls_e;

   typedef enum logic [1:0] {
      DP_NOP = 2'd0,
      DP_MRD = 2'd1,
      DP_MWR = 2'd2
   } dp_code_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/pmdram_rowtrack.sv
// Open-row register and access classification.
module pmdram_rowtrack
   import pmdram_pkg::*;
#(
   parameter int unsigned MA_W        = 11,
   parameter int unsigned LAT_W       = 5,
   parameter int unsigned RD_HIT      = 7,
   parameter int unsigned RD_ROWMISS  = 11,
   parameter int unsigned RD_PAGEMISS = 14,
   parameter int unsigned RD_CLOSED   = 10,
   parameter int unsigned WR_HIT      = 12,
   parameter int unsigned WR_ROWMISS  = 13,
   parameter int unsigned WR_PAGEMISS = 16,
   parameter int unsigned WR_CLOSED   = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic             close_mode,
   input  logic             is_write,
   input  logic [MA_W-1:0]  row,
   output acc_cls_e         cls,
   output logic             need_pre,
   output logic [LAT_W-1:0] first_lat,
   output logic             open_valid
);
   logic [MA_W-1:0] open_row;

   always_comb begin
      if (close_mode)               cls = ACC_CLOSED;
      else if (!open_valid)         cls = ACC_ROWMISS;
      else if (row == open_row)     cls = ACC_HIT;
      else                          cls = ACC_PAGEMISS;
      need_pre = open_valid && ((cls == ACC_PAGEMISS) || (cls == ACC_CLOSED));
      unique case (cls)
         ACC_HIT:      first_lat = is_write ? LAT_W'(WR_HIT)      : LAT_W'(RD_HIT);
         ACC_ROWMISS:  first_lat = is_write ? LAT_W'(WR_ROWMISS)  : LAT_W'(RD_ROWMISS);
         ACC_PAGEMISS: first_lat = is_write ? LAT_W'(WR_PAGEMISS) : LAT_W'(RD_PAGEMISS);
         default:      first_lat = is_write ? LAT_W'(WR_CLOSED)   : LAT_W'(RD_CLOSED);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_valid <= 1'b0;
         open_row   <= '0;
      end else if (accept) begin
         open_valid <= !close_mode;
         open_row   <= row;
      end
   end

   // R4: a closed-mode access never leaves a row marked open
   assert_closed_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && close_mode) |=> !open_valid);
endmodule

// File: rtl/pmdram_beatctl.sv
// Transfer pacing: one down-counter per transfer plus beat index.
module pmdram_beatctl #(
   parameter int unsigned LAT_W    = 5,
   parameter int unsigned NEXT_LAT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic             burst,
   input  logic [LAT_W-1:0] first_lat,
   output logic             busy,
   output logic             rdy,
   output logic             last,
   output logic             first,
   output logic [1:0]       beat,
   output logic [LAT_W-1:0] cnt,
   output logic [LAT_W-1:0] age
);
   logic burst_q;

   assign rdy  = busy && (cnt == '0);
   assign last = (beat == (burst_q ? 2'd3 : 2'd0));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         cnt     <= '0;
         beat    <= 2'd0;
         first   <= 1'b0;
         burst_q <= 1'b0;
         age     <= '0;
      end else if (!busy) begin
         if (accept) begin
            busy    <= 1'b1;
            cnt     <= first_lat - LAT_W'(1);
            beat    <= 2'd0;
            first   <= 1'b1;
            burst_q <= burst;
            age     <= '0;
         end
      end else begin
         if (first && (age != '1)) age <= age + LAT_W'(1);
         if (cnt == '0) begin
            if (last) begin
               busy  <= 1'b0;
               first <= 1'b0;
            end else begin
               cnt   <= LAT_W'(NEXT_LAT - 1);
               beat  <= beat + 2'd1;
               first <= 1'b0;
            end
         end else begin
            cnt <= cnt - LAT_W'(1);
         end
      end
   end

   // R5: the ready strobe is a single-cycle pulse
   assert_rdy_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rdy |=> !rdy);
   // R5: a burst never advances past its fourth transfer
   assert_beat_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy && last) |=> !busy);
endmodule

// File: rtl/pmdram_strobes.sv
// DRAM strobe, address, data-path code and latch-enable decode.
module pmdram_strobes
   import pmdram_pkg::*;
#(
   parameter int unsigned MA_W     = 11,
   parameter int unsigned CAS_N    = 8,
   parameter int unsigned LAT_W    = 5,
   parameter int unsigned CAS_W    = 2,
   parameter int unsigned PRE      = 3,
   parameter int unsigned COL_LEAD = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             busy,
   input  logic             rdy,
   input  logic             last,
   input  logic             first,
   input  logic [1:0]       beat,
   input  logic [LAT_W-1:0] cnt,
   input  logic [LAT_W-1:0] age,
   input  logic             hit_q,
   input  logic             pre_q,
   input  logic             wr_q,
   input  logic             open_valid,
   input  logic [MA_W-1:0]  row_q,
   input  logic [MA_W-1:0]  col_q,
   output logic             ras_n,
   output logic [CAS_N-1:0] cas_n,
   output logic [MA_W-1:0]  ma,
   output logic [1:0]       dp_code,
   output logic             mdle
);
   logic ras_on, cas_on, col_phase, mdle_low_q;
   dp_code_e dp;

   always_comb begin
      if (busy) ras_on = !(first && pre_q && (age < LAT_W'(PRE)));
      else      ras_on = open_valid;
      cas_on    = busy && (cnt < LAT_W'(CAS_W));
      col_phase = !first || hit_q || (cnt < LAT_W'(COL_LEAD));
      if (col_phase) ma = {col_q[MA_W-1:2], col_q[1:0] ^ beat};
      else           ma = row_q;
      if (busy && !(rdy && last)) dp = wr_q ? DP_MWR : DP_MRD;
      else                        dp = DP_NOP;
   end

   assign ras_n   = !ras_on;
   assign dp_code = dp;
   assign mdle    = !mdle_low_q;

   for (genvar i = 0; i < CAS_N; i++) begin : g_lane
      assign cas_n[i] = !cas_on;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mdle_low_q <= 1'b0;
      else        mdle_low_q <= rdy && !wr_q;
   end

   // R7: every lane strobes in a transfer's ready cycle
   assert_cas_at_rdy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rdy |-> (cas_n == '0));
   // R10: the row is open whenever data moves
   assert_ras_at_rdy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rdy |-> !ras_n);
   // R8: latch closes only as CAS is released after a ready strobe
   assert_mdle_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mdle) |-> ((cas_n == '1) && $past(rdy)));
   // R6: only the two low column bits move between transfers
   assert_burst_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy && !last) |=> (ma[MA_W-1:2] == $past(ma[MA_W-1:2])));
endmodule

// File: rtl/pmdram_seq.sv
// Page-mode DRAM access sequencer top.
module pmdram_seq
   import pmdram_pkg::*;
#(
   parameter int unsigned MA_W        = 11,
   parameter int unsigned CAS_N       = 8,
   parameter int unsigned RD_HIT      = 7,
   parameter int unsigned RD_ROWMISS  = 11,
   parameter int unsigned RD_PAGEMISS = 14,
   parameter int unsigned RD_CLOSED   = 10,
   parameter int unsigned WR_HIT      = 12,
   parameter int unsigned WR_ROWMISS  = 13,
   parameter int unsigned WR_PAGEMISS = 16,
   parameter int unsigned WR_CLOSED   = 12,
   parameter int unsigned NEXT_LAT    = 4,
   parameter int unsigned CAS_W       = 2,
   parameter int unsigned PRE         = 3,
   parameter int unsigned COL_LEAD    = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                close_mode,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic                req_burst,
   input  logic [2*MA_W-1:0]   req_addr,
   output logic                req_ready,
   output logic                cpu_rdy,
   output logic                ras_n,
   output logic [CAS_N-1:0]    cas_n,
   output logic [MA_W-1:0]     ma,
   output logic [1:0]          dp_code,
   output logic                mdle
);
   localparam int unsigned ADDR_W  = 2 * MA_W;
   localparam int unsigned MAX_RD  = max2(max2(RD_HIT, RD_ROWMISS), max2(RD_PAGEMISS, RD_CLOSED));
   localparam int unsigned MAX_WR  = max2(max2(WR_HIT, WR_ROWMISS), max2(WR_PAGEMISS, WR_CLOSED));
   localparam int unsigned MAX_LAT = max2(max2(MAX_RD, MAX_WR), NEXT_LAT);
   localparam int unsigned LAT_W   = $clog2(MAX_LAT + 1);
   localparam int unsigned MIN_MISS = PRE + COL_LEAD + 1;

   initial begin
      if (MA_W < 2)                 $fatal(1, "MA_W must cover the burst bits");
      if (CAS_W < 1 || COL_LEAD < CAS_W) $fatal(1, "column lead shorter than CAS window");
      if (NEXT_LAT <= CAS_W)        $fatal(1, "CAS must release between transfers");
      if (RD_HIT < COL_LEAD || WR_HIT < COL_LEAD) $fatal(1, "hit latency too short");
      if (RD_PAGEMISS < MIN_MISS || WR_PAGEMISS < MIN_MISS ||
          RD_CLOSED < MIN_MISS || WR_CLOSED < MIN_MISS ||
          RD_ROWMISS < COL_LEAD + 1 || WR_ROWMISS < COL_LEAD + 1)
                                    $fatal(1, "miss latency below precharge plus column lead");
   end

   logic             busy, accept, rdy, last, first, need_pre, open_valid;
   logic [1:0]       beat;
   logic [LAT_W-1:0] cnt, age, first_lat;
   acc_cls_e         cls;
   logic [MA_W-1:0]  row_in, col_in, row_q, col_q;
   logic             wr_q, hit_q, pre_q;

   assign row_in    = req_addr[ADDR_W-1:MA_W];
   assign col_in    = req_addr[MA_W-1:0];
   assign req_ready = !busy;
   assign accept    = req_valid && !busy;
   assign cpu_rdy   = rdy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q <= '0;
         col_q <= '0;
         wr_q  <= 1'b0;
         hit_q <= 1'b0;
         pre_q <= 1'b0;
      end else if (accept) begin
         row_q <= row_in;
         col_q <= col_in;
         wr_q  <= req_write;
         hit_q <= (cls == ACC_HIT);
         pre_q <= need_pre;
      end
   end

   pmdram_rowtrack #(
      .MA_W(MA_W), .LAT_W(LAT_W),
      .RD_HIT(RD_HIT), .RD_ROWMISS(RD_ROWMISS), .RD_PAGEMISS(RD_PAGEMISS), .RD_CLOSED(RD_CLOSED),
      .WR_HIT(WR_HIT), .WR_ROWMISS(WR_ROWMISS), .WR_PAGEMISS(WR_PAGEMISS), .WR_CLOSED(WR_CLOSED)
   ) u_rowtrack (
      .clk(clk), .rst_n(rst_n), .accept(accept), .close_mode(close_mode),
      .is_write(req_write), .row(row_in), .cls(cls), .need_pre(need_pre),
      .first_lat(first_lat), .open_valid(open_valid)
   );

   pmdram_beatctl #(.LAT_W(LAT_W), .NEXT_LAT(NEXT_LAT)) u_beatctl (
      .clk(clk), .rst_n(rst_n), .accept(accept), .burst(req_burst),
      .first_lat(first_lat), .busy(busy), .rdy(rdy), .last(last),
      .first(first), .beat(beat), .cnt(cnt), .age(age)
   );

   pmdram_strobes #(
      .MA_W(MA_W), .CAS_N(CAS_N), .LAT_W(LAT_W), .CAS_W(CAS_W),
      .PRE(PRE), .COL_LEAD(COL_LEAD)
   ) u_strobes (
      .clk(clk), .rst_n(rst_n), .busy(busy), .rdy(rdy), .last(last),
      .first(first), .beat(beat), .cnt(cnt), .age(age), .hit_q(hit_q),
      .pre_q(pre_q), .wr_q(wr_q), .open_valid(open_valid), .row_q(row_q),
      .col_q(col_q), .ras_n(ras_n), .cas_n(cas_n), .ma(ma),
      .dp_code(dp_code), .mdle(mdle)
   );

   // R11: no ready strobe while the sequencer advertises idle
   assert_rdy_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rdy |-> !req_ready);
   // R11: a taken request makes the sequencer busy next cycle
   assert_accept_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
endmodule

// File: tb/sim_pmdram_seq.sv
module sim_pmdram_seq;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 11;
   // {pre, write, burst, close, row[10:0], col[10:0], first latency[4:0]}
   localparam logic [30:0] VEC [NV] = '{
      {1'b0, 1'b0, 1'b1, 1'b0, 11'd5, 11'h012, 5'd11},
      {1'b0, 1'b0, 1'b1, 1'b0, 11'd5, 11'h041, 5'd7},
      {1'b0, 1'b1, 1'b0, 1'b0, 11'd5, 11'h100, 5'd12},
      {1'b1, 1'b0, 1'b1, 1'b0, 11'd9, 11'h003, 5'd14},
      {1'b0, 1'b1, 1'b1, 1'b0, 11'd9, 11'h202, 5'd12},
      {1'b1, 1'b1, 1'b0, 1'b0, 11'd3, 11'h055, 5'd16},
      {1'b1, 1'b0, 1'b0, 1'b1, 11'd3, 11'h006, 5'd10},
      {1'b0, 1'b1, 1'b1, 1'b1, 11'd3, 11'h011, 5'd12},
      {1'b0, 1'b1, 1'b0, 1'b0, 11'd7, 11'h7FF, 5'd13},
      {1'b0, 1'b0, 1'b0, 1'b0, 11'd7, 11'h010, 5'd7},
      {1'b1, 1'b0, 1'b1, 1'b1, 11'd7, 11'h00D, 5'd10}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic close_mode = 1'b0, req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0;
   logic [21:0] req_addr = '0;
   logic req_ready, cpu_rdy, ras_n, mdle;
   logic [7:0] cas_n;
   logic [10:0] ma;
   logic [1:0] dp_code;
   int n_chk = 0, n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pmdram_seq u0 (
      .clk(clk), .rst_n(rst_n), .close_mode(close_mode), .req_valid(req_valid),
      .req_write(req_write), .req_burst(req_burst), .req_addr(req_addr),
      .req_ready(req_ready), .cpu_rdy(cpu_rdy), .ras_n(ras_n), .cas_n(cas_n),
      .ma(ma), .dp_code(dp_code), .mdle(mdle)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic run_vec(input logic [30:0] v);
      bit pre = v[30], wr = v[29], bu = v[28], cl = v[27];
      logic [10:0] row = v[26:16], col = v[15:5];
      int lat = int'(v[4:0]);
      int nb = bu ? 4 : 1;
      int beat = 0;
      bit prev_rd = 0, prev_rdy = 0;
      string tag = cl ? "R4" : (wr ? "R3" : "R2");
      @(negedge clk);
      chk(req_ready == 1'b1, "R11 idle before request", int'(req_ready), 1);
      req_valid = 1'b1; req_write = wr; req_burst = bu; close_mode = cl;
      req_addr = {row, col};
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk(ras_n == pre, "R10 ras at first busy cycle", int'(ras_n), int'(pre));
      chk(req_ready == 1'b0, "R11 busy after accept", int'(req_ready), 0);
      chk(dp_code == (wr ? 2'd2 : 2'd1), "R9 code during access", int'(dp_code), wr ? 2 : 1);
      for (int k = 0; k < 400 && beat < nb; k++) begin
         if (k > 0) @(negedge clk);
         chk(mdle == !prev_rd, "R8 latch enable", int'(mdle), int'(!prev_rd));
         if (prev_rdy) chk(cas_n == 8'hFF, "R7 cas released", int'(cas_n), 255);
         prev_rd = 0; prev_rdy = 0;
         if (cpu_rdy) begin
            chk(k == lat - 1 + 4 * beat, beat == 0 ? tag : "R5",
                k + 1, lat + 4 * beat);
            chk(ma == {col[10:2], col[1:0] ^ 2'(beat)}, "R6 burst column",
                int'(ma), int'({col[10:2], col[1:0] ^ 2'(beat)}));
            chk(cas_n == 8'h00, "R7 cas at ready", int'(cas_n), 0);
            chk(ras_n == 1'b0, "R10 ras at ready", int'(ras_n), 0);
            if (beat == nb - 1) chk(dp_code == 2'd0, "R9 nop at final ready", int'(dp_code), 0);
            prev_rd = !wr; prev_rdy = 1;
            beat++;
         end
      end
      chk(beat == nb, "R5 transfer count", beat, nb);
      @(negedge clk);
      chk(mdle == !prev_rd, "R8 latch after last", int'(mdle), int'(!prev_rd));
      chk(cas_n == 8'hFF, "R7 cas idle", int'(cas_n), 255);
      chk(cpu_rdy == 1'b0, "R5 no extra ready", int'(cpu_rdy), 0);
      chk(req_ready == 1'b1, "R11 idle after access", int'(req_ready), 1);
      chk(dp_code == 2'd0, "R9 nop idle", int'(dp_code), 0);
      chk(ras_n == cl, cl ? "R4 row closed" : "R10 row kept open", int'(ras_n), int'(cl));
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      int k;
      #(CLK_PERIOD * 3 + 1);
      // R1: reset state
      chk(ras_n == 1'b1, "R1 ras_n", int'(ras_n), 1);
      chk(cas_n == 8'hFF, "R1 cas_n", int'(cas_n), 255);
      chk(cpu_rdy == 1'b0, "R1 cpu_rdy", int'(cpu_rdy), 0);
      chk(dp_code == 2'd0, "R1 dp_code", int'(dp_code), 0);
      chk(mdle == 1'b1, "R1 mdle", int'(mdle), 1);
      chk(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ras_n == 1'b1 && cpu_rdy == 1'b0, "R1 after release", int'(ras_n), 1);

      for (int i = 0; i < NV; i++) run_vec(VEC[i]);

      // Back-to-back: read row miss, then a page-miss write waiting on req_valid
      @(negedge clk);
      close_mode = 1'b0; req_valid = 1'b1; req_write = 1'b0; req_burst = 1'b0;
      req_addr = {11'd2, 11'h020};
      @(posedge clk);
      @(negedge clk);
      req_write = 1'b1; req_addr = {11'd4, 11'h031};
      k = 0;
      while (!cpu_rdy && k < 100) begin @(negedge clk); k++; end
      chk(k == 10, "R2 row miss read before successor", k + 1, 11);
      @(negedge clk); k++;
      chk(mdle == 1'b0, "R8 latch closes with next accept", int'(mdle), 0);
      chk(req_ready == 1'b1, "R11 ready in shared cycle", int'(req_ready), 1);
      @(negedge clk); k++;
      req_valid = 1'b0;
      chk(ras_n == 1'b1, "R10 precharge for successor", int'(ras_n), 1);
      while (!cpu_rdy && k < 200) begin @(negedge clk); k++; end
      chk(k == 27, "R3 page miss write after shared cycle", k - 11, 16);
      @(negedge clk);
      chk(mdle == 1'b1, "R8 no latch pulse for write", int'(mdle), 1);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule